// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, in each cycle, which hardware thread of a multithreaded core may fetch instructions. Each thread reports a 3-bit fetch state and an active bit. From these the block works out which threads are fit to fetch, and it returns a valid flag and the chosen thread id in the same cycle.

Two static policies exist. In round-robin mode the block keeps the thread ids in a priority list. It scans the list from its head and grants the first fit thread. On the clock edge that ends a granted cycle, the winner moves to the tail of the list and every other entry keeps its relative place. In single-thread mode only thread 0 can be granted, and only when the block is built for exactly one thread. A drain request holds back every grant and freezes the list.

Top module: `fetch_thread_picker`

## Requirements
- R1: A thread's state sits in `thread_status[3*i+2:3*i]`. Only the codes 0 (idle), 1 (running) and 6 (line fill complete) make the thread fit to fetch. Codes 2 (squashing), 3 (blocked), 4 (waiting for a response), 5 (waiting to retry) and 7 never do.
- R2: A thread whose `thread_active[i]` bit is 0 is never granted, whatever its state.
- R3: In round-robin mode (`single_mode`=0), `sel_valid` and `sel_id` report, in the same cycle, the first fit thread found when the list is scanned from its head.
- R4: After a round-robin grant, the list at the next clock edge has the granted id at its tail, and all other ids keep their previous relative order.
- R5: If no listed thread is fit, `sel_valid` is 0 and the list order is left unchanged.
- R6: While `drain_req` is 1, `sel_valid` is 0 and the list order is left unchanged.
- R7: After reset the list holds the ids in ascending order, with thread 0 at the head.
- R8: In single-thread mode the list never changes. With one thread built in, thread 0 is granted when fit and nothing is granted otherwise. With more than one thread built in, this mode is illegal and no grant is made.
- R9: With one thread built in, round-robin mode grants thread 0 when it is fit and nothing otherwise.
- R10: `sel_id` reads 0 whenever `sel_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thread_status | input | 3*NUM_THREADS | Fetch state code of each thread, 3 bits per thread |
| thread_active | input | NUM_THREADS | Thread is active |
| single_mode | input | 1 | 1 selects single-thread policy, 0 selects round-robin |
| drain_req | input | 1 | Suppresses all grants and list updates |
| sel_valid | output | 1 | A thread is granted this cycle |
| sel_id | output | ID_W | Granted thread id, 0 when no grant |

## Verification
Each of the eight state codes is tried alone on one thread, to separate the fit codes from the unfit ones. All-fit patterns run after reset and after a second reset, and they expose the starting order and the head-to-tail rotation. Patterns with a single fit thread in the middle of the list show whether only the winner moves, because a later all-fit sweep must then return the others in their old order. Drain, single-thread mode and idle patterns appear between grants to show that the list stays frozen. A long pseudo-random mix of states, active masks and modes is compared every cycle against a queue model, both on the four-thread build and on a one-thread build.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;

  typedef enum logic [2:0] {
    FS_IDLE       = 3'd0,
    FS_RUN        = 3'd1,
    FS_SQUASH     = 3'd2,
    FS_BLOCKED    = 3'd3,
    FS_WAIT_RESP  = 3'd4,
    FS_WAIT_RETRY = 3'd5,
    FS_FILL_DONE  = 3'd6,
    FS_RSVD       = 3'd7
  } fetch_state_e;

  localparam int unsigned MAX_THREADS = 4;
  localparam int unsigned STATE_W     = 3;

  // A thread may fetch when idle, running or just after a line fill.
  function automatic logic state_can_fetch(input logic [STATE_W-1:0] code);
    fetch_state_e s;
    s = fetch_state_e'(code);
    return (s == FS_IDLE) || (s == FS_RUN) || (s == FS_FILL_DONE);
  endfunction

  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fsel_eligibility.sv
`timescale 1ns/1ps
module fsel_eligibility #(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [3*NUM_THREADS-1:0] thread_status,
  input  logic [NUM_THREADS-1:0]   thread_active,
  output logic [NUM_THREADS-1:0]   fit_vec
);
  import fsel_pkg::*;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [STATE_W-1:0] code;
    assign code       = thread_status[STATE_W*t +: STATE_W];
    assign fit_vec[t] = thread_active[t] & state_can_fetch(code);
  end

endmodule

// File: rtl/fsel_order_list.sv
`timescale 1ns/1ps
module fsel_order_list #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ID_W        = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  input  logic [ID_W-1:0]             win_pos,
  output logic [NUM_THREADS*ID_W-1:0] order_flat
);

  logic [ID_W-1:0] slot_q [NUM_THREADS];
  logic [ID_W-1:0] slot_d [NUM_THREADS];
  logic [ID_W-1:0] win_id;

  assign win_id = slot_q[win_pos];

  for (genvar p = 0; p < NUM_THREADS; p++) begin : g_slot
    localparam logic [ID_W-1:0] POS = ID_W'(p);
    if (p == NUM_THREADS - 1) begin : g_tail
      assign slot_d[p] = win_id;
    end else begin : g_body
      assign slot_d[p] = (POS < win_pos) ? slot_q[p] : slot_q[p+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[p] <= POS;
      else if (advance) slot_q[p] <= slot_d[p];
    end

    assign order_flat[ID_W*p +: ID_W] = slot_q[p];
  end

  // Presence map, brought out for the permutation check.
  logic [NUM_THREADS-1:0] id_seen;
  always_comb begin
    id_seen = '0;
    for (int p = 0; p < NUM_THREADS; p++) id_seen[slot_q[p]] = 1'b1;
  end

  AST_LIST_IS_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(id_seen) == NUM_THREADS); // R4

  AST_LIST_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(order_flat)); // R5

endmodule

// File: rtl/fsel_scan.sv
`timescale 1ns/1ps
module fsel_scan #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ID_W        = 2
) (
  input  logic [NUM_THREADS*ID_W-1:0] order_flat,
  input  logic [NUM_THREADS-1:0]      fit_vec,
  output logic                        found,
  output logic [ID_W-1:0]             found_pos,
  output logic [ID_W-1:0]             found_id
);

  // Walk from tail to head so that the head-most hit is kept last.
  always_comb begin
    found     = 1'b0;
    found_pos = '0;
    found_id  = '0;
    for (int p = NUM_THREADS - 1; p >= 0; p--) begin
      if (fit_vec[order_flat[ID_W*p +: ID_W]]) begin
        found     = 1'b1;
        found_pos = ID_W'(p);
        found_id  = order_flat[ID_W*p +: ID_W];
      end
    end
  end

endmodule

// File: rtl/fetch_thread_picker.sv
`timescale 1ns/1ps
module fetch_thread_picker #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ID_W        = fsel_pkg::id_width(NUM_THREADS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3*NUM_THREADS-1:0] thread_status,
  input  logic [NUM_THREADS-1:0]   thread_active,
  input  logic                     single_mode,
  input  logic                     drain_req,
  output logic                     sel_valid,
  output logic [ID_W-1:0]          sel_id
);

  localparam bit SINGLE_LEGAL = (NUM_THREADS == 1);

  logic [NUM_THREADS-1:0]      fit_vec;
  logic [NUM_THREADS*ID_W-1:0] order_flat;
  logic                        rr_found;
  logic [ID_W-1:0]             rr_pos;
  logic [ID_W-1:0]             rr_id;
  logic                        rr_grant;
  logic                        one_grant;
  logic [ID_W-1:0]             tail_id;

  fsel_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thread_status (thread_status),
    .thread_active (thread_active),
    .fit_vec       (fit_vec)
  );

  fsel_scan #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_scan (
    .order_flat (order_flat),
    .fit_vec    (fit_vec),
    .found      (rr_found),
    .found_pos  (rr_pos),
    .found_id   (rr_id)
  );

  assign rr_grant  = rr_found & ~single_mode & ~drain_req;
  assign one_grant = SINGLE_LEGAL & single_mode & ~drain_req & fit_vec[0];

  fsel_order_list #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_list (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (rr_grant),
    .win_pos    (rr_pos),
    .order_flat (order_flat)
  );

  assign sel_valid = rr_grant | one_grant;
  assign sel_id    = rr_grant ? rr_id : '0;
  assign tail_id   = order_flat[ID_W*(NUM_THREADS-1) +: ID_W];

  AST_GRANT_IS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> fit_vec[sel_id]); // R1

  AST_INACTIVE_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> thread_active[sel_id]); // R2

  AST_WINNER_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !single_mode) |=> tail_id == $past(sel_id)); // R4

  AST_NONE_FIT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (fit_vec == '0) |-> !sel_valid); // R5

  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> (!sel_valid && !u_list.advance)); // R6

  AST_SINGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |=> $stable(order_flat)); // R8

  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> sel_id == '0); // R10

endmodule

// File: tb/fetch_thread_picker_tb.sv
`timescale 1ns/1ps
module fetch_thread_picker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] status = '0;
  logic [3:0]  active = '0;
  logic        single = 1'b0;
  logic        drain = 1'b0;
  logic        v4, v1;
  logic [1:0]  id4;
  logic [0:0]  id1;

  int total = 0;
  int bad = 0;
  int q4[$];
  int q1[$];

  always #2 clk = ~clk;  // 250 MHz

  fetch_thread_picker #(.NUM_THREADS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .thread_status(status), .thread_active(active),
    .single_mode(single), .drain_req(drain), .sel_valid(v4), .sel_id(id4)
  );

  fetch_thread_picker #(.NUM_THREADS(1)) u_one (
    .clk(clk), .rst_n(rst_n), .thread_status(status[2:0]), .thread_active(active[0:0]),
    .single_mode(single), .drain_req(drain), .sel_valid(v1), .sel_id(id1)
  );

  function automatic bit fit(input int t);
    int c;
    c = int'(status[3*t +: 3]);
    return active[t] && (c == 0 || c == 1 || c == 6);
  endfunction

  function automatic void expect_of(input int nt, input int q[$], output bit ev, output int eid,
                                    output int epos);
    ev = 0; eid = 0; epos = 0;
    if (drain) return;
    if (single) begin
      if (nt == 1 && fit(0)) ev = 1;
      return;
    end
    for (int p = 0; p < q.size(); p++) begin
      if (fit(q[p])) begin ev = 1; eid = q[p]; epos = p; return; end
    end
  endfunction

  task automatic check(input string req, input int act_v, input int act_id, input int exp_v,
                       input int exp_id);
    total++;
    if (act_v != exp_v || act_id != exp_id) begin
      bad++;
      $display("FAIL %s: actual valid=%0d id=%0d expected valid=%0d id=%0d", req, act_v, act_id,
               exp_v, exp_id);
    end
  endtask

  function automatic string auto_tag(input bit one);
    if (drain) return "R6";
    if (single) return "R8";
    return one ? "R9" : "R3";
  endfunction

  task automatic reset_model();
    q4 = '{0, 1, 2, 3};
    q1 = '{0};
  endtask

  task automatic step(input logic [11:0] st, input logic [3:0] act, input logic sg, input logic dr,
                      input string tag);
    bit ev; int eid; int epos; string t;
    @(negedge clk);
    status = st; active = act; single = sg; drain = dr;
    #1;
    expect_of(4, q4, ev, eid, epos);
    t = (tag != "") ? tag : (ev || drain || single) ? auto_tag(0) : "R5";
    check(t, int'(v4), int'(id4), int'(ev), eid);
    if (!ev) check("R10", 0, int'(id4), 0, 0);
    if (ev && !single) begin q4.delete(epos); q4.push_back(eid); end
    expect_of(1, q1, ev, eid, epos);
    t = (tag == "R7" || tag == "R1") ? tag : auto_tag(1);
    check(t, int'(v1), int'(id1), int'(ev), eid);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: nothing active, nothing granted
    step(12'h000, 4'h0, 0, 0, "R5");
    // R7: ascending start order
    for (int k = 0; k < 5; k++) step({4{3'd1}}, 4'hF, 0, 0, "R7");
    // R1: every code on thread 1 alone
    for (int c = 0; c < 8; c++) step(12'(c) << 3, 4'b0010, 0, 0, "R1");
    // R2: inactive threads skipped
    for (int k = 0; k < 4; k++) step({4{3'd1}}, 4'b0101, 0, 0, "R2");
    // R4: lone middle winner then full sweep keeps others in order
    step({3'd3, 3'd0, 3'd3, 3'd3}, 4'hF, 0, 0, "R4");
    for (int k = 0; k < 4; k++) step({4{3'd6}}, 4'hF, 0, 0, "R4");
    // R6 and R8 freeze the list; R5 idle
    step({4{3'd1}}, 4'hF, 0, 1, "R6");
    step({4{3'd1}}, 4'hF, 1, 0, "R8");
    step({4{3'd4}}, 4'hF, 0, 0, "R5");
    for (int k = 0; k < 4; k++) step({4{3'd1}}, 4'hF, 0, 0, "R4");
    // R9/R8 on the one-thread build
    step(12'h001, 4'h1, 1, 0, "");
    step(12'h002, 4'h1, 1, 0, "");
    // pseudo-random mix
    for (int k = 0; k < 600; k++) begin
      logic [11:0] s; logic [3:0] a; logic sg, dr;
      s  = 12'($urandom);
      a  = 4'($urandom);
      sg = ($urandom % 8) == 0;
      dr = ($urandom % 10) == 0;
      step(s, a, sg, dr, "");
    end
    // R7: reset again restores ascending order
    @(negedge clk); rst_n = 1'b0;
    reset_model();
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step({4{3'd0}}, 4'hF, 0, 0, "R7");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule